// File: doc/BRIEF.md
# Single-Precision Floating-Point Comparator

This block takes two IEEE-754 single-precision operands, A and B, and returns four flags: greater, equal, less and unordered. Each operand is first classified from its bit pattern: NaN, zero or an ordinary finite or infinite value. The classifications and the raw bit patterns then feed one compare step, whose result is held in an output register. The operands are 1 sign bit, 8 exponent bits and 23 fraction bits, from most to least significant.

A new operand pair may be presented on every cycle while the enable input is high. Each result appears one clock after its operands, so the block has full throughput. Holding the enable low freezes the output register. A synchronous reset clears all four flags.

Top module: `fp32_cmp_pipe`

## Requirements
- R1: With `en` high at a rising edge, the flags reflect the operands sampled at that edge from that edge on. A new pair can be accepted on every cycle.
- R2: With `en` low at a rising edge, all four flags keep their previous values, whatever the operands are.
- R3: `rst` high at a rising edge clears all four flags to 0.
- R4: An operand is a NaN when its exponent bits [30:23] are all ones and its fraction bits [22:0] are nonzero. If either operand is a NaN, `unord_o` is 1 and `gt_o`, `eq_o` and `lt_o` are 0.
- R5: Positive zero (0x00000000) and negative zero (0x80000000) compare as equal in any pairing.
- R6: After an enabled compare, exactly one of the four flags is 1. `unord_o` is 1 only when the operands are unordered.
- R7: For non-NaN operands of opposite sign (bit 31), where not both are zero, the operand with sign 0 is the greater.
- R8: Two positive operands are ordered by the unsigned value of bits [30:0]. For two negative operands, that order is reversed.
- R9: Infinity (exponent all ones, fraction zero) compares above every finite value of the same sign. Two infinities of the same sign are equal.
- R10: Denormals (exponent zero, fraction nonzero) compare by their raw fraction. They lie below the smallest normal value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Compare enable; when low, the flags hold |
| a_in | input | 32 | Operand A, single precision |
| b_in | input | 32 | Operand B, single precision |
| gt_o | output | 1 | A greater than B |
| eq_o | output | 1 | A equal to B |
| lt_o | output | 1 | A less than B |
| unord_o | output | 1 | Operands unordered (a NaN is present) |

## Verification
The assertions assume that `en`, `rst`, `a_in` and `b_in` are driven to known values at every sampled edge. They also assume that reset is applied before the first enabled cycle, because the output register has no defined value before then. The bench asserts reset from time zero and changes all inputs only at falling edges. It therefore always presents fully specified operands, covering NaNs, infinities, signed zeros and denormals. The properties are judged only on cycles after reset has been released.

// File: rtl/fp32_cmp_pipe.sv
module fp32_cmp_pipe #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         en,
  input  logic [EXP_W+MAN_W:0]         a_in,
  input  logic [EXP_W+MAN_W:0]         b_in,
  output logic                         gt_o,
  output logic                         eq_o,
  output logic                         lt_o,
  output logic                         unord_o
);
  localparam int W   = EXP_W + MAN_W + 1;
  localparam int MSB = W - 1;

  logic [EXP_W-1:0] a_exp, b_exp;
  logic [MAN_W-1:0] a_man, b_man;
  logic [W-2:0]     a_mag, b_mag;
  logic             a_sgn, b_sgn;
  logic             a_nan, b_nan, a_zero, b_zero;

  assign a_sgn  = a_in[MSB];
  assign b_sgn  = b_in[MSB];
  assign a_exp  = a_in[W-2:MAN_W];
  assign b_exp  = b_in[W-2:MAN_W];
  assign a_man  = a_in[MAN_W-1:0];
  assign b_man  = b_in[MAN_W-1:0];
  assign a_mag  = a_in[W-2:0];
  assign b_mag  = b_in[W-2:0];
  assign a_nan  = (&a_exp) && (|a_man);
  assign b_nan  = (&b_exp) && (|b_man);
  assign a_zero = ~|a_mag;
  assign b_zero = ~|b_mag;

  logic n_gt, n_eq, n_lt, n_un;
  logic mag_gt, mag_lt;

  assign mag_gt = a_mag > b_mag;
  assign mag_lt = a_mag < b_mag;

  always_comb begin
    n_gt = 1'b0;
    n_eq = 1'b0;
    n_lt = 1'b0;
    n_un = 1'b0;
    if (a_nan || b_nan) begin
      n_un = 1'b1;
    end else if (a_zero && b_zero) begin
      n_eq = 1'b1;
    end else if (a_sgn != b_sgn) begin
      n_gt = b_sgn;
      n_lt = a_sgn;
    end else if (!mag_gt && !mag_lt) begin
      n_eq = 1'b1;
    end else begin
      n_gt = a_sgn ? mag_lt : mag_gt;
      n_lt = a_sgn ? mag_gt : mag_lt;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gt_o    <= 1'b0;
      eq_o    <= 1'b0;
      lt_o    <= 1'b0;
      unord_o <= 1'b0;
    end else if (en) begin
      gt_o    <= n_gt;
      eq_o    <= n_eq;
      lt_o    <= n_lt;
      unord_o <= n_un;
    end
  end

  assert_reset_R3: assert property (@(posedge clk)
    rst |=> {gt_o, eq_o, lt_o, unord_o} == 4'b0000);

  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (!rst && !en) |=> $stable({gt_o, eq_o, lt_o, unord_o}));

  assert_onehot_R6: assert property (@(posedge clk) disable iff (rst)
    (!rst && en) |=> $countones({gt_o, eq_o, lt_o, unord_o}) == 1);

  assert_nan_R4: assert property (@(posedge clk) disable iff (rst)
    (!rst && en && (a_nan || b_nan)) |=> (unord_o && !gt_o && !eq_o && !lt_o));

  assert_zero_R5: assert property (@(posedge clk) disable iff (rst)
    (!rst && en && a_in[W-2:0] == '0 && b_in[W-2:0] == '0) |=> eq_o);

  assert_sign_R7: assert property (@(posedge clk) disable iff (rst)
    (!rst && en && !a_nan && !b_nan && (a_sgn != b_sgn) && !(a_zero && b_zero))
      |=> (gt_o == !$past(a_sgn)) && (lt_o == $past(a_sgn)));

  assert_unord_only_R6: assert property (@(posedge clk) disable iff (rst)
    unord_o |-> !(gt_o || eq_o || lt_o));
endmodule

// File: tb/sim_fp32_cmp_pipe.sv
module sim_fp32_cmp_pipe;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en  = 1'b0;
  logic [31:0] a_in = '0, b_in = '0;
  logic gt_o, eq_o, lt_o, unord_o;

  int n_run  = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  fp32_cmp_pipe u0 (
    .clk(clk), .rst(rst), .en(en), .a_in(a_in), .b_in(b_in),
    .gt_o(gt_o), .eq_o(eq_o), .lt_o(lt_o), .unord_o(unord_o)
  );

  // {a, b, expected {gt,eq,lt,unord}}
  localparam logic [67:0] VEC [20] = '{
    {32'h3f800000, 32'h40000000, 4'b0010},  // R8 1 < 2
    {32'h40000000, 32'h3f800000, 4'b1000},  // R8
    {32'h3f800000, 32'h3f800000, 4'b0100},  // R8 equal
    {32'h00000000, 32'h80000000, 4'b0100},  // R5 +0 == -0
    {32'hbf800000, 32'hc0000000, 4'b1000},  // R8 -1 > -2
    {32'hc0000000, 32'hbf800000, 4'b0010},  // R8
    {32'h3f800000, 32'hbf800000, 4'b1000},  // R7
    {32'h80000001, 32'h00000000, 4'b0010},  // R7 -denorm < +0
    {32'h00000001, 32'h00000002, 4'b0010},  // R10
    {32'h007fffff, 32'h00800000, 4'b0010},  // R10 below min normal
    {32'h7f800000, 32'h7f7fffff, 4'b1000},  // R9 inf > max finite
    {32'h7f800000, 32'h7f800000, 4'b0100},  // R9
    {32'hff800000, 32'hff800000, 4'b0100},  // R9
    {32'hff800000, 32'h7f800000, 4'b0010},  // R9 R7
    {32'h7fc00000, 32'h3f800000, 4'b0001},  // R4
    {32'h3f800000, 32'hffc00001, 4'b0001},  // R4
    {32'h7f800001, 32'h7f800000, 4'b0001},  // R4 NaN vs inf
    {32'h7fc00000, 32'h7fc00000, 4'b0001},  // R4
    {32'h80000000, 32'h00000001, 4'b0010},  // R7 -0 < +denorm
    {32'hc0490fdb, 32'hc0490fda, 4'b0010}   // R8 negative reversed
  };

  task automatic check(input logic [3:0] exp_f, input string req);
    n_run++;
    if ({gt_o, eq_o, lt_o, unord_o} !== exp_f) begin
      n_fail++;
      $display("FAIL %s: flags got %b expected %b (a=%h b=%h)", req,
               {gt_o, eq_o, lt_o, unord_o}, exp_f, a_in, b_in);
    end
  endtask

  initial begin
    #2000000;
    n_run++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    check(4'b0000, "R3 reset state");
    rst = 1'b0;

    // R1: one pair per cycle, each result checked one cycle later
    en = 1'b1;
    for (int i = 0; i < 20; i++) begin
      a_in = VEC[i][67:36];
      b_in = VEC[i][35:4];
      @(negedge clk);
      check(VEC[i][3:0], "R1 vector");
    end

    // R2: enable low holds the last result (lt) despite new operands
    en = 1'b0;
    a_in = 32'h7fc00000;
    b_in = 32'h00000000;
    repeat (3) @(negedge clk);
    check(4'b0010, "R2 hold");
    en = 1'b1;
    @(negedge clk);
    check(4'b0001, "R2 resume R4");

    // R6 / R9: -inf below negative finite
    a_in = 32'hff800000;
    b_in = 32'hc2c80000;
    @(negedge clk);
    check(4'b0010, "R9 -inf");

    // R3: reset in mid-run clears flags even with enable high
    a_in = 32'h40000000;
    b_in = 32'h3f800000;
    rst = 1'b1;
    @(negedge clk);
    check(4'b0000, "R3 mid-run reset");
    rst = 1'b0;
    @(negedge clk);
    check(4'b1000, "R1 after reset R8");

    // R5: -0 vs -0
    a_in = 32'h80000000;
    b_in = 32'h80000000;
    @(negedge clk);
    check(4'b0100, "R5 -0 -0");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule